// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a single memory and decides, for every write-type request, whether the write may reach the array. A request port carries a valid strobe, an operation code, a physical address and the ID of the hardware context that issued it. Load-linked requests open a reservation. Store-conditional requests succeed only while that reservation is still intact. Ordinary stores always write, and they break any reservation on the block they touch.

Reservations cover aligned 16-byte blocks: the low four address bits are cleared before an address is stored or compared. A small table holds up to `ENTRIES` reservations, each a masked address and an owning context. A context never holds more than one reservation. When the table is full, a new load-linked overwrites slots in round-robin order. Both decisions are combinational and are given in the same cycle as the request. The table update takes effect at the next clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: A synchronous active-high `rst` empties the table. A store-conditional issued first after reset gives `wr_en`=0 and `sc_result`=0.
- R2: A valid ordinary store (`req_op`=2) always gives `wr_en`=1 and `sc_result`=0 in the same cycle, whether or not the table is empty.
- R3: A store-conditional (`req_op`=3) whose masked address and context both match a valid entry gives `wr_en`=1 and `sc_result`=1 in the same cycle. The low four address bits are ignored, so any byte of the 16-byte block matches. The entry is the one opened by a load-linked (`req_op`=1) from that context.
- R4: A store-conditional from a context that owns no entry for the block fails (`wr_en`=0, `sc_result`=0). It still clears every entry on that block, including entries of other contexts.
- R5: A store-conditional to a different 16-byte block than the reservation fails. The reservation on the original block stays valid.
- R6: A valid ordinary store clears every entry whose masked address equals the store's masked address. Entries on other blocks are kept.
- R7: A successful store-conditional clears every entry on its block, so an immediate repeat of it fails.
- R8: A load-linked first drops any entry already owned by the same context. Only the newest reservation of a context can then succeed.
- R9: A load-linked takes the lowest-numbered free slot. When no slot is free, it overwrites the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at `ENTRIES`, only on such an overwrite.
- R10: A request with `req_valid`=0 has no effect on the table. A load (`req_op`=0) also has no effect on the table.
- R11: `wr_en` and `sc_result` are 0 when `req_valid`=0, and also when the operation is a load or a load-linked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, empties the table |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 load, 1 load-linked, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting hardware-context ID |
| wr_en | output | 1 | Write permitted for this request (combinational) |
| sc_result | output | 1 | Store-conditional result value, 1 success, 0 failure |

## Verification
A bad table state is visible only through store-conditional outcomes. A stale valid bit or a missed clear shows as a conditional that succeeds when it should fail. A lost entry, a wrong masked address or a wrong owner shows as a conditional that fails when it should succeed. Each fault shows in the same cycle as the first conditional that probes the damaged block. The bench therefore follows every table-changing sequence (clears, same-context replacement, round-robin eviction) with conditionals on each affected block and on untouched neighbours.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_LL    = 2'd1,
        OP_STORE = 2'd2,
        OP_SC    = 2'd3
    } llsc_op_e;
endpackage

// File: rtl/llsc_slot_match.sv
module llsc_slot_match #(
    parameter int ADDR_W = 32,
    parameter int CTX_W  = 4
) (
    input  logic              slot_vld,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [CTX_W-1:0]  slot_ctx,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [CTX_W-1:0]  cmp_ctx,
    output logic              blk_hit,
    output logic              ctx_hit,
    output logic              own_hit
);
    always_comb begin
        blk_hit = slot_vld && (slot_addr == cmp_addr);
        ctx_hit = slot_vld && (slot_ctx == cmp_ctx);
        own_hit = blk_hit && ctx_hit;
    end
endmodule

// File: rtl/llsc_victim_sel.sv
module llsc_victim_sel #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] free_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               uses_free
);
    always_comb begin
        slot      = rr_ptr;
        uses_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                slot      = IDX_W'(i);
                uses_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ADDR_W     = 32,
    parameter int CTX_W      = 4,
    parameter int ENTRIES    = 4,
    parameter int GRAIN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              wr_en,
    output logic              sc_result
);
    import llsc_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << GRAIN_BITS) - ADDR_W'(1));
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic [ENTRIES-1:0][CTX_W-1:0]  ctx;
        logic [IDX_W-1:0]               rr;
    } table_t;

    table_t st_d, st_q;

    logic [ADDR_W-1:0]  req_blk;
    logic [ENTRIES-1:0] blk_hit, ctx_hit, own_hit;
    logic [ENTRIES-1:0] keep_vec;
    logic [IDX_W-1:0]   vic_slot;
    logic               vic_free;
    logic               is_store, is_sc, is_ll, sc_ok;

    assign req_blk = req_addr & BLK_MASK;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        llsc_slot_match #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_match (
            .slot_vld (st_q.vld[g]),
            .slot_addr(st_q.addr[g]),
            .slot_ctx (st_q.ctx[g]),
            .cmp_addr (req_blk),
            .cmp_ctx  (req_ctx),
            .blk_hit  (blk_hit[g]),
            .ctx_hit  (ctx_hit[g]),
            .own_hit  (own_hit[g])
        );
    end

    assign keep_vec = st_q.vld & ~ctx_hit;

    llsc_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .free_vec (~keep_vec),
        .rr_ptr   (st_q.rr),
        .slot     (vic_slot),
        .uses_free(vic_free)
    );

    always_comb begin
        is_store = req_valid && (req_op == OP_STORE);
        is_sc    = req_valid && (req_op == OP_SC);
        is_ll    = req_valid && (req_op == OP_LL);
        sc_ok    = is_sc && (|own_hit);

        st_d = st_q;
        if (is_store || is_sc) begin
            st_d.vld = st_q.vld & ~blk_hit;
        end
        if (is_ll) begin
            st_d.vld           = keep_vec;
            st_d.vld[vic_slot]  = 1'b1;
            st_d.addr[vic_slot] = req_blk;
            st_d.ctx[vic_slot]  = req_ctx;
            if (!vic_free) begin
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + IDX_W'(1);
            end
        end

        wr_en     = is_store || sc_ok;
        sc_result = sc_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W     = 32,
    parameter int CTX_W      = 4,
    parameter int GRAIN_BITS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CTX_W-1:0]  req_ctx,
    input logic              wr_en,
    input logic              sc_result
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << GRAIN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] blk;
    assign blk = req_addr & BLK_MASK;

    AST_FIRST_SC_FAILS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid && req_op == 2'd3) |-> !sc_result); // R1

    AST_STORE_WRITES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2) |-> (wr_en && !sc_result)); // R2

    AST_SC_SUCCESS_WRITES: assert property (@(posedge clk) disable iff (rst)
        sc_result |-> wr_en); // R3

    AST_LL_THEN_SC_OK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && req_op == 2'd1) && req_valid && req_op == 2'd3
         && blk == $past(blk) && req_ctx == $past(req_ctx)) |-> sc_result); // R3

    AST_SC_REPEAT_FAILS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && req_op == 2'd3 && sc_result)
         && req_valid && req_op == 2'd3 && blk == $past(blk)) |-> !sc_result); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_op == 2'd0 || req_op == 2'd1) |-> (!wr_en && !sc_result)); // R11
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W(ADDR_W), .CTX_W(CTX_W), .GRAIN_BITS(GRAIN_BITS)
) u_chk (.*);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;
    localparam int AW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_ctx = '0;
    logic          wr_en, sc_result;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    llsc_monitor #(.ADDR_W(AW), .CTX_W(CW), .ENTRIES(4), .GRAIN_BITS(4)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_ctx(req_ctx), .wr_en(wr_en), .sc_result(sc_result)
    );

    localparam logic [1:0] LD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic req(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [CW-1:0] c, input logic exp_we, input logic exp_res,
                       input string tag);
        @(negedge clk);
        req_valid = v;
        req_op    = op;
        req_addr  = a;
        req_ctx   = c;
        #2;
        n_cmp++;
        if (wr_en !== exp_we || sc_result !== exp_res) begin
            n_bad++;
            $display("FAIL %s: wr_en/sc_result = %b/%b expected %b/%b",
                     tag, wr_en, sc_result, exp_we, exp_res);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        req(1, SC, 32'h0000_0100, 4'd1, 0, 0, "R1 sc after reset");
        req(1, ST, 32'h0000_0100, 4'd1, 1, 0, "R2 store on empty table");
    endtask

    task automatic t_basic();
        do_reset();
        req(1, LL, 32'h0000_1004, 4'd1, 0, 0, "R11 ll quiet");
        req(1, SC, 32'h0000_100C, 4'd1, 1, 1, "R3 sc same block");
        req(1, SC, 32'h0000_1000, 4'd1, 0, 0, "R7 repeat sc fails");
    endtask

    task automatic t_ctx();
        do_reset();
        req(1, LL, 32'h0000_2000, 4'd2, 0, 0, "R11 ll quiet");
        req(1, SC, 32'h0000_2008, 4'd3, 0, 0, "R4 foreign ctx sc fails");
        req(1, SC, 32'h0000_2000, 4'd2, 0, 0, "R4 foreign sc cleared entry");
    endtask

    task automatic t_other_blk();
        do_reset();
        req(1, LL, 32'h0000_3000, 4'd2, 0, 0, "R11 ll quiet");
        req(1, SC, 32'h0000_3010, 4'd2, 0, 0, "R5 other block fails");
        req(1, SC, 32'h0000_300F, 4'd2, 1, 1, "R5 reservation kept");
    endtask

    task automatic t_store();
        do_reset();
        req(1, LL, 32'h0000_4000, 4'd4, 0, 0, "R11 ll quiet");
        req(1, LL, 32'h0000_5000, 4'd5, 0, 0, "R11 ll quiet");
        req(1, ST, 32'h0000_4008, 4'd7, 1, 0, "R2 store writes");
        req(1, SC, 32'h0000_4000, 4'd4, 0, 0, "R6 store cleared block");
        req(1, SC, 32'h0000_5004, 4'd5, 1, 1, "R6 other block kept");
    endtask

    task automatic t_one_per_ctx();
        do_reset();
        req(1, LL, 32'h0000_6000, 4'd6, 0, 0, "R11 ll quiet");
        req(1, LL, 32'h0000_7000, 4'd6, 0, 0, "R11 ll quiet");
        req(1, SC, 32'h0000_6000, 4'd6, 0, 0, "R8 old reservation dropped");
        req(1, SC, 32'h0000_7000, 4'd6, 1, 1, "R8 new reservation holds");
    endtask

    task automatic t_quiet();
        do_reset();
        req(1, LL, 32'h0000_8000, 4'd8, 0, 0, "R11 ll quiet");
        req(0, SC, 32'h0000_8000, 4'd8, 0, 0, "R11 invalid sc quiet");
        req(0, ST, 32'h0000_8000, 4'd9, 0, 0, "R11 invalid store quiet");
        req(1, LD, 32'h0000_8000, 4'd9, 0, 0, "R11 load quiet");
        req(1, SC, 32'h0000_8004, 4'd8, 1, 1, "R10 reservation untouched");
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 4; i++)
            req(1, LL, 32'h0001_0000 + 32'(i) * 32'h100, 4'(i), 0, 0, "R9 fill");
        req(1, LL, 32'h0001_0400, 4'd4, 0, 0, "R9 evict slot0");
        req(1, LL, 32'h0001_0500, 4'd5, 0, 0, "R9 evict slot1");
        req(1, SC, 32'h0001_0000, 4'd0, 0, 0, "R9 ctx0 evicted");
        req(1, SC, 32'h0001_0100, 4'd1, 0, 0, "R9 ctx1 evicted");
        req(1, SC, 32'h0001_0200, 4'd2, 1, 1, "R9 ctx2 kept");
        req(1, SC, 32'h0001_0300, 4'd3, 1, 1, "R9 ctx3 kept");
        req(1, SC, 32'h0001_0400, 4'd4, 1, 1, "R9 ctx4 stored");
        req(1, SC, 32'h0001_0500, 4'd5, 1, 1, "R9 ctx5 stored");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ctx();
        t_other_blk();
        t_store();
        t_one_per_ctx();
        t_quiet();
        t_round_robin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule